// File: doc/BRIEF.md
# Valley-Triggered Switching Cycle Scheduler

This block decides the clock on which each new switching cycle of a quasi-resonant power converter controller begins. It watches a synchronized one-clock valley-detect pulse from an external comparator and sends a one-clock start-of-cycle strobe to the gate pulse generator. Every timer counts from the strobe of the previous cycle.

The block holds off valleys that come too soon, so the switching period never drops below a set minimum. After that blanking window the first valley starts the next cycle. A valley that fell inside the blanking window is remembered. If no later valley follows, a fallback deadline a fixed number of clocks past the minimum period starts the cycle. If no valley is seen at all, a long starter timeout forces a cycle so the converter never stalls. All three lengths are parameters in clock cycles.

A low enable holds every timer and the blanking memory cleared and blocks the strobe. When enable goes high, the first strobe follows right away.

Top module: `valley_cycle_sched`

## Requirements
- R1: While reset is asserted or enable is sampled low, cycle_start stays 0.
- R2: When enable is sampled high on a clock edge while the block is idle, cycle_start is 1 in the cycle right after that edge.
- R3: cycle_start is never high for two consecutive cycles, and two strobes are at least MIN_PERIOD clocks apart.
- R4: A valley sampled fewer than MIN_PERIOD clocks after the previous strobe does not start a cycle.
- R5: A valley sampled on the edge that ends clock k after a strobe, with k >= MIN_PERIOD, makes cycle_start high k clocks after the previous strobe.
- R6: With no valley at all, the next strobe comes exactly STARTER clocks after the previous one.
- R7: If one or more valleys fell inside the blanking window and none came after it, the strobe comes MIN_PERIOD + FALLBACK clocks after the previous one.
- R8: The memory of blanked valleys is cleared at every strobe. A cycle with no valleys that follows a fallback-started cycle therefore lasts STARTER clocks.
- R9: When the fallback and starter deadlines fall on the same clock, only one strobe is issued.
- R10: Dropping enable mid-cycle discards all timing. After enable returns, the first strobe comes at once and the next deadlines count from it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Scheduler run enable |
| valley | input | 1 | Synchronized one-clock valley-detect pulse |
| cycle_start | output | 1 | One-clock strobe that starts a switching cycle |

## Verification
The bench aims at the edges of the blanking window. It puts a valley on the last blanked clock and on the first open clock. A design that is off by one would start the cycle a clock early, or let the valley fall through to the fallback deadline. It checks that a blanked valley leads to the fallback deadline and that the next idle cycle goes back to the full starter timeout. A design that never clears the blanking memory would end that idle cycle early. A second instance sets the fallback and starter deadlines to the same clock, where a design that strobes once for each deadline would give a two-clock pulse. Random valley trains with occasional enable drops are compared clock by clock against a bench model.

// File: rtl/sched_pkg.sv
package sched_pkg;

    typedef struct packed {
        logic run;
        logic start;
    } sched_state_t;

    typedef struct packed {
        logic seen;
    } blank_mem_t;

endpackage

// File: rtl/sched_timer.sv
module sched_timer #(
    parameter int MIN_PERIOD = 850,
    parameter int FALLBACK   = 500,
    parameter int STARTER    = 1300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic restart,
    output logic in_blank,
    output logic fb_point,
    output logic st_point
);
    localparam int CW        = $clog2(STARTER + 1);
    localparam int BLANK_END = MIN_PERIOD - 1;
    localparam int FB_AT     = MIN_PERIOD + FALLBACK - 1;
    localparam int ST_AT     = STARTER - 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } timer_t;

    timer_t tm_q, tm_d;

    always_comb begin
        tm_d = tm_q;
        if (clear || restart) begin
            tm_d.cnt = '0;
        end else if (tm_q.cnt != CW'(ST_AT)) begin
            tm_d.cnt = tm_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tm_q <= '0;
        end else begin
            tm_q <= tm_d;
        end
    end

    assign in_blank = (tm_q.cnt < CW'(BLANK_END));
    assign st_point = (tm_q.cnt == CW'(ST_AT));

    generate
        if (FB_AT <= ST_AT) begin : g_fb_live
            assign fb_point = (tm_q.cnt == CW'(FB_AT));
        end else begin : g_fb_dead
            assign fb_point = 1'b0;
        end
    endgenerate

    // R6: the elapsed count never runs past the starter deadline
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tm_q.cnt <= CW'(ST_AT));

    // R10: a clear returns the count to zero on the next clock
    p_clear_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> in_blank || (BLANK_END == 0));

endmodule

// File: rtl/sched_blank_mem.sv
module sched_blank_mem (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic mark,
    output logic seen
);
    import sched_pkg::*;

    blank_mem_t mem_q, mem_d;

    always_comb begin
        mem_d = mem_q;
        if (clear) begin
            mem_d.seen = 1'b0;
        end else if (mark) begin
            mem_d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign seen = mem_q.seen;

    // R8: a clear always wins over a mark on the same clock
    p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !seen);

    // R7: a blanked valley is held until the next clear
    p_mark_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !clear) |=> seen);

endmodule

// File: rtl/valley_cycle_sched.sv
module valley_cycle_sched #(
    parameter int MIN_PERIOD = 850,
    parameter int FALLBACK   = 500,
    parameter int STARTER    = 1300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic valley,
    output logic cycle_start
);
    import sched_pkg::*;

    sched_state_t st_q, st_d;

    logic in_blank;
    logic fb_point;
    logic st_point;
    logic seen;
    logic valley_take;
    logic fb_take;
    logic st_take;
    logic mark;
    logic mem_clear;

    sched_timer #(
        .MIN_PERIOD (MIN_PERIOD),
        .FALLBACK   (FALLBACK),
        .STARTER    (STARTER)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (!enable),
        .restart  (st_d.start),
        .in_blank (in_blank),
        .fb_point (fb_point),
        .st_point (st_point)
    );

    sched_blank_mem u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (mem_clear),
        .mark  (mark),
        .seen  (seen)
    );

    always_comb begin
        valley_take = st_q.run && valley && !in_blank;
        fb_take     = st_q.run && seen && fb_point;
        st_take     = st_q.run && st_point;
        mark        = enable && st_q.run && valley && in_blank;

        st_d       = st_q;
        st_d.run   = enable;
        st_d.start = enable && (!st_q.run || valley_take || fb_take || st_take);

        mem_clear = !enable || st_d.start;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cycle_start = st_q.start;

    // R1: nothing is issued after enable was sampled low
    p_quiet_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !cycle_start);

    // R2: enable seen high while idle gives a strobe on the next clock
    p_first_after_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !st_q.run) |=> cycle_start);

    // R3: the strobe lasts exactly one clock
    p_pulse_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |=> !cycle_start);

    // R4: no strobe may follow a clock spent inside the blanking window
    p_blank_respected_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && enable && in_blank) |=> !cycle_start);

    // R8: the blanked-valley memory is empty whenever a strobe is out
    p_mem_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |-> !seen);

endmodule

// File: tb/valley_cycle_sched_tb.sv
module valley_cycle_sched_tb;

    localparam int MINP = 12;
    localparam int FB   = 6;
    localparam int ST   = 40;
    localparam int ST_EQ = MINP + FB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic valley = 1'b0;
    logic en2 = 1'b0;
    logic v2 = 1'b0;
    logic cycle_start;
    logic cs2;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    // bench model state
    bit m_run = 1'b0;
    int m_off = 0;
    bit m_early = 1'b0;
    bit m_start = 1'b0;
    bit obs = 1'b0;

    always #4 clk = ~clk;

    valley_cycle_sched #(.MIN_PERIOD(MINP), .FALLBACK(FB), .STARTER(ST)) u_dut (
        .clk (clk), .rst_n (rst_n), .enable (enable), .valley (valley),
        .cycle_start (cycle_start)
    );

    valley_cycle_sched #(.MIN_PERIOD(MINP), .FALLBACK(FB), .STARTER(ST_EQ)) u_dut_eq (
        .clk (clk), .rst_n (rst_n), .enable (en2), .valley (v2),
        .cycle_start (cs2)
    );

    function automatic bit model_fire(bit early, int off, bit v);
        return (v && off >= MINP - 1) || (early && off == MINP + FB - 1) || (off == ST - 1);
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_step(bit en, bit v);
        bit s;
        if (!rst_n || !en) begin
            m_run = 0; m_off = 0; m_early = 0; m_start = 0;
        end else if (!m_run) begin
            m_run = 1; m_off = 0; m_early = 0; m_start = 1;
        end else begin
            s = model_fire(m_early, m_off, v);
            m_early = s ? 1'b0 : (m_early || (v && m_off < MINP - 1));
            m_off = s ? 0 : m_off + 1;
            m_start = s;
        end
    endtask

    task automatic tick(bit en, bit v, string tag);
        @(negedge clk);
        enable = en;
        valley = v;
        @(posedge clk);
        model_step(en, v);
        #1;
        obs = cycle_start;
        check(obs == m_start, tag, int'(obs), int'(m_start));
    endtask

    task automatic run_cycle(int va, int vb, int exp, string tag);
        int got = 0;
        for (int j = 1; j <= 100; j++) begin
            tick(1'b1, (j == va) || (j == vb), tag);
            if (obs) begin
                got = j;
                break;
            end
        end
        check(got == exp, tag, got, exp);
    endtask

    task automatic tick_eq(bit v);
        @(negedge clk);
        en2 = 1'b1;
        v2 = v;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int first;
        int extra;
        void'($urandom(32'd4242));

        // R1: reset holds the strobe low
        repeat (3) begin
            @(posedge clk);
            #1;
            check(cycle_start == 1'b0, "R1 reset", int'(cycle_start), 0);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1: disabled, valleys do nothing
        for (int i = 0; i < 5; i++) tick(1'b0, i[0], "R1 disabled");

        // R2: first strobe right after enable
        tick(1'b1, 1'b0, "R2");
        check(obs == 1'b1, "R2 first strobe", int'(obs), 1);

        run_cycle(0, 0, ST, "R6 starter");
        run_cycle(3, 0, MINP + FB, "R7 fallback");
        run_cycle(0, 0, ST, "R8 memory cleared");
        run_cycle(MINP - 1, MINP, MINP, "R4 blank then open");
        run_cycle(MINP, 0, MINP, "R5 first open clock");
        run_cycle(5, MINP + 3, MINP + 3, "R5 late valley");
        run_cycle(MINP - 1, 0, MINP + FB, "R4 last blanked clock");
        run_cycle(1, 0, MINP + FB, "R7 valley at clock one");

        // R10: drop enable mid-cycle, then restart
        for (int i = 0; i < 7; i++) tick(1'b1, 1'b0, "R10 partial");
        for (int i = 0; i < 3; i++) tick(1'b0, 1'b1, "R10 off");
        tick(1'b1, 1'b0, "R10");
        check(obs == 1'b1, "R10 restart strobe", int'(obs), 1);
        run_cycle(0, 0, ST, "R10 fresh timing");

        // R9: coinciding deadlines on the second instance
        tick(1'b0, 1'b0, "R1 park");
        tick_eq(1'b0);
        check(cs2 == 1'b1, "R9 eq first strobe", int'(cs2), 1);
        first = 0;
        extra = 0;
        for (int j = 1; j <= ST_EQ + 1; j++) begin
            tick_eq(j == 2);
            if (cs2 && first == 0) first = j;
            else if (cs2) extra++;
        end
        check(first == ST_EQ, "R9 single deadline strobe", first, ST_EQ);
        check(extra == 0, "R9 no second strobe", extra, 0);

        // R3 / R5: random valley trains against the model
        begin
            bit en_r = 1'b1;
            int last = -1;
            for (int i = 0; i < 4000; i++) begin
                if (en_r) en_r = ($urandom % 150) != 0;
                else en_r = ($urandom % 3) == 0;
                tick(en_r, ($urandom % 7) == 0, "R5 random");
                if (obs) begin
                    if (last >= 0 && en_r) check(i - last >= MINP, "R3 spacing", i - last, MINP);
                    last = i;
                end
                if (!en_r) last = -1;
            end
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule